// File: doc/BRIEF.md
# Translation Buffer Permission Lookup

This block is a small fully associative translation buffer for an embedded processor core. Each entry holds a valid flag, an effective page tag, an owning process identifier, a real page number, one address-space flag and an eight-bit permission byte. A lookup request presents an effective address, an access kind (fetch, read or write), the privilege level and the current process identifier. It also presents the instruction-side and data-side translation-space flags from the machine state. One clock later the block returns a real address, the granted permission nibble and a status code.

The search runs over the entries in index order. An entry takes part only when its address-space flag agrees with the space flag for the kind of access. A permission failure on one entry does not end the search, so a later entry with the same page can still grant the access. The first granting entry supplies the real address. If entries match but none grants, a failure code is returned. Software loads entries one at a time through an indexed write port. Pages are a fixed 4 KiB.

Top module: `tlbp_lookup`

## Requirements
- R1: After reset, rsp_valid is 0 and every entry is invalid, so any lookup reports a miss.
- R2: When wr_en is high at a clock edge, the entry at wr_idx takes the written fields, and a lookup presented in the following cycle sees the new entry.
- R3: An entry matches when it is valid, its tag equals req_ea[31:12], and its process ID equals cur_pid or is zero (global). The real address on success is the entry's real page number followed by req_ea[11:0].
- R4: A fetch (req_kind 2'b00) considers only entries whose address-space flag equals is_bit. A read (2'b01 or 2'b11) or a write (2'b10) considers only entries whose flag equals ds_bit. Other entries count as not matching.
- R5: The permission nibble is perm[3:0] when req_priv is 0 (user) and perm[7:4] when req_priv is 1 (supervisor). Within a nibble, bit 0 allows read, bit 1 allows write and bit 2 allows execute.
- R6: A fetch needs the execute bit and otherwise fails with status 3'b101 (-3). A read needs the read bit and a write needs the write bit, and otherwise each fails with status 3'b110 (-2). Success is status 3'b000.
- R7: The lowest-index matching entry that grants the access wins, even when an earlier matching entry denied it. If matching entries exist but none grants, rsp_perm is the nibble of the highest-index matching entry.
- R8: If no entry matches, the status is 3'b111 (-1) and rsp_perm is 0.
- R9: rsp_ra is 0 whenever the status is not 3'b000.
- R10: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write an entry this cycle |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid flag for the written entry |
| wr_tag | input | 20 | Effective page tag |
| wr_pid | input | 8 | Owning process ID (0 = global) |
| wr_rpn | input | 20 | Real page number |
| wr_as | input | 1 | Address-space flag |
| wr_perm | input | 8 | Permission byte: [7:4] supervisor, [3:0] user |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| cur_pid | input | 8 | Current process ID |
| is_bit | input | 1 | Instruction-side translation space |
| ds_bit | input | 1 | Data-side translation space |
| rsp_valid | output | 1 | Response strobe |
| rsp_ra | output | 32 | Real address (0 on fault) |
| rsp_perm | output | 4 | Selected permission nibble |
| rsp_status | output | 3 | 000 ok, 111 miss, 110 rights, 101 no-execute |

## Verification
The bench sets up pages where an earlier entry denies and a later entry with the same tag grants. A design that stopped at the first match would return a failure in these cases, and one that took the last grant would return the wrong real page. Address-space flags are flipped against the access kind. This catches a design that compares a fetch against the data-side flag, or that treats a space mismatch as a denial instead of a miss. Global entries, invalidated entries and all-deny cases are included. The all-deny cases show whether the kept nibble and the fetch-versus-data failure code come from the right entry and access kind.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int EA_W     = 32;
    localparam int RA_W     = 32;
    localparam int PID_W    = 8;
    localparam int PG_OFF_W = 12;
    localparam int TAG_W    = EA_W - PG_OFF_W;
    localparam int RPN_W    = RA_W - PG_OFF_W;
    localparam int PERM_W   = 8;
    localparam int NIB_W    = PERM_W / 2;

    localparam int NB_READ  = 0;
    localparam int NB_WRITE = 1;
    localparam int NB_EXEC  = 2;

    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_READ  = 2'b01,
        K_WRITE = 2'b10,
        K_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_OK     = 3'b000,
        ST_MISS   = 3'b111,
        ST_DENY   = 3'b110,
        ST_NOEXEC = 3'b101
    } lk_status_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PID_W-1:0]  pid;
        logic [RPN_W-1:0]  rpn;
        logic              aspace;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;

    // Privilege picks the upper (supervisor) or lower (user) nibble.
    function automatic logic [NIB_W-1:0] pick_nibble(logic [PERM_W-1:0] p, logic sup);
        return sup ? p[PERM_W-1:NIB_W] : p[NIB_W-1:0];
    endfunction

    // The single nibble bit that a given access kind requires.
    function automatic logic needed_bit(logic [NIB_W-1:0] nib, acc_kind_e kind);
        case (kind)
            K_FETCH: return nib[NB_EXEC];
            K_WRITE: return nib[NB_WRITE];
            default: return nib[NB_READ];
        endcase
    endfunction

endpackage

// File: rtl/tlbp_entry_store.sv
module tlbp_entry_store
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_entry_t           wr_entry,
    output tlb_entry_t           ents [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents[g] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/tlbp_match.sv
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t           ents [ENTRIES],
    input  logic [TAG_W-1:0]     ea_tag,
    input  acc_kind_e            kind,
    input  logic                 sup,
    input  logic [PID_W-1:0]     pid,
    input  logic                 is_bit,
    input  logic                 ds_bit,
    output logic [ENTRIES-1:0]   hit,
    output logic [ENTRIES-1:0]   grant,
    output logic [NIB_W-1:0]     nib [ENTRIES]
);

    logic space;
    assign space = (kind == K_FETCH) ? is_bit : ds_bit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic pid_ok;
        assign pid_ok = (ents[g].pid == pid) || (ents[g].pid == '0);
        assign hit[g] = ents[g].valid
                     && (ents[g].tag == ea_tag)
                     && pid_ok
                     && (ents[g].aspace == space);
        assign nib[g]   = pick_nibble(ents[g].perm, sup);
        assign grant[g] = hit[g] && needed_bit(nib[g], kind);
    end

endmodule

// File: rtl/tlbp_select.sv
module tlbp_select
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  tlb_entry_t             ents [ENTRIES],
    input  logic [ENTRIES-1:0]     hit,
    input  logic [ENTRIES-1:0]     grant,
    input  logic [NIB_W-1:0]       nib [ENTRIES],
    input  logic [PG_OFF_W-1:0]    ea_off,
    input  acc_kind_e              kind,
    output lk_status_e             status,
    output logic [NIB_W-1:0]       perm,
    output logic [RA_W-1:0]        ra
);

    logic             found;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] last_idx;

    // First granting entry in index order; last matching entry kept for faults.
    always_comb begin
        found    = 1'b0;
        any_hit  = 1'b0;
        win_idx  = '0;
        last_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i] && !found) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
            end
            if (hit[i]) begin
                any_hit  = 1'b1;
                last_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            status = ST_OK;
            perm   = nib[win_idx];
            ra     = {ents[win_idx].rpn, ea_off};
        end else if (any_hit) begin
            status = (kind == K_FETCH) ? ST_NOEXEC : ST_DENY;
            perm   = nib[last_idx];
            ra     = '0;
        end else begin
            status = ST_MISS;
            perm   = '0;
            ra     = '0;
        end
    end

endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [PID_W-1:0]     wr_pid,
    input  logic [RPN_W-1:0]     wr_rpn,
    input  logic                 wr_as,
    input  logic [PERM_W-1:0]    wr_perm,
    input  logic                 req_valid,
    input  logic [EA_W-1:0]      req_ea,
    input  logic [1:0]           req_kind,
    input  logic                 req_priv,
    input  logic [PID_W-1:0]     cur_pid,
    input  logic                 is_bit,
    input  logic                 ds_bit,
    output logic                 rsp_valid,
    output logic [RA_W-1:0]      rsp_ra,
    output logic [NIB_W-1:0]     rsp_perm,
    output logic [2:0]           rsp_status
);

    tlb_entry_t           wr_entry;
    tlb_entry_t           ents [ENTRIES];
    acc_kind_e            kind;
    logic [ENTRIES-1:0]   hit;
    logic [ENTRIES-1:0]   grant;
    logic [NIB_W-1:0]     nib [ENTRIES];
    lk_status_e           nxt_status;
    logic [NIB_W-1:0]     nxt_perm;
    logic [RA_W-1:0]      nxt_ra;

    assign wr_entry = '{valid: wr_valid, tag: wr_tag, pid: wr_pid,
                        rpn: wr_rpn, aspace: wr_as, perm: wr_perm};
    assign kind     = acc_kind_e'(req_kind);

    tlbp_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    tlbp_match #(.ENTRIES(ENTRIES)) u_match (
        .ents   (ents),
        .ea_tag (req_ea[EA_W-1:PG_OFF_W]),
        .kind   (kind),
        .sup    (req_priv),
        .pid    (cur_pid),
        .is_bit (is_bit),
        .ds_bit (ds_bit),
        .hit    (hit),
        .grant  (grant),
        .nib    (nib)
    );

    tlbp_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_select (
        .ents   (ents),
        .hit    (hit),
        .grant  (grant),
        .nib    (nib),
        .ea_off (req_ea[PG_OFF_W-1:0]),
        .kind   (kind),
        .status (nxt_status),
        .perm   (nxt_perm),
        .ra     (nxt_ra)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_ra     <= '0;
            rsp_perm   <= '0;
            rsp_status <= ST_OK;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ra     <= nxt_ra;
                rsp_perm   <= nxt_perm;
                rsp_status <= nxt_status;
            end
        end
    end

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker
    import tlbp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic [PG_OFF_W-1:0] req_off,
    input logic                rsp_valid,
    input logic [RA_W-1:0]     rsp_ra,
    input logic [NIB_W-1:0]    rsp_perm,
    input logic [2:0]          rsp_status
);

    // R1: the first cycle after reset carries no response
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R10: response strobe follows the request by one cycle
    a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R6: only the defined status encodings appear
    a_r6_status_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status == 3'b000 || rsp_status == 3'b111 ||
                       rsp_status == 3'b110 || rsp_status == 3'b101));

    // R6: no-execute only for fetches, rights violation only for data
    a_r6_noexec_on_fetch: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'b101) |-> ($past(req_kind) == 2'b00));
    a_r6_deny_on_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'b110) |-> ($past(req_kind) != 2'b00));

    // R5: a granted fetch carries the execute bit in the returned nibble
    a_r5_fetch_has_exec: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'b000 && $past(req_kind) == 2'b00)
            |-> rsp_perm[NB_EXEC]);

    // R3: page offset passes through unchanged on success
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'b000) |-> (rsp_ra[PG_OFF_W-1:0] == $past(req_off)));

    // R9: no real address leaks out on a fault
    a_r9_ra_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 3'b000) |-> (rsp_ra == '0));

    // R8: a miss returns an empty nibble
    a_r8_miss_no_perm: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'b111) |-> (rsp_perm == '0));

endmodule

bind tlbp_lookup tlbp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_off    (req_ea[tlbp_pkg::PG_OFF_W-1:0]),
    .rsp_valid  (rsp_valid),
    .rsp_ra     (rsp_ra),
    .rsp_perm   (rsp_perm),
    .rsp_status (rsp_status)
);

// File: tb/test_tlbp_lookup.sv
`timescale 1ns/1ps
module test_tlbp_lookup;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic        wr_valid;
    logic [19:0] wr_tag;
    logic [7:0]  wr_pid;
    logic [19:0] wr_rpn;
    logic        wr_as;
    logic [7:0]  wr_perm;
    logic        req_valid;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        req_priv;
    logic [7:0]  cur_pid;
    logic        is_bit;
    logic        ds_bit;
    logic        rsp_valid;
    logic [31:0] rsp_ra;
    logic [3:0]  rsp_perm;
    logic [2:0]  rsp_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tlbp_lookup i_tlbp_lookup (.*);

    localparam logic [2:0] S_OK = 3'b000, S_MISS = 3'b111, S_DENY = 3'b110, S_NX = 3'b101;
    localparam logic [1:0] KF = 2'b00, KR = 2'b01, KW = 2'b10, KX = 2'b11;

    typedef struct packed {
        logic [31:0] ea;
        logic [1:0]  kind;
        logic        sup;
        logic [7:0]  pid;
        logic        isb;
        logic        dsb;
        logic [2:0]  st;
        logic [31:0] ra;
        logic [3:0]  perm;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0123, KR, 1'b0, 8'd5, 1'b0, 1'b0, S_OK,   32'hA001_0123, 4'h7}, // R3 R5 user
        '{32'h0001_0123, KF, 1'b0, 8'd5, 1'b0, 1'b0, S_OK,   32'hA001_0123, 4'h7}, // R6
        '{32'h0001_0123, KF, 1'b1, 8'd5, 1'b0, 1'b0, S_OK,   32'hB001_0123, 4'h4}, // R7 later grant
        '{32'h0001_0123, KW, 1'b1, 8'd5, 1'b0, 1'b0, S_OK,   32'hA001_0123, 4'h3}, // R5 supervisor
        '{32'h0001_0123, KW, 1'b0, 8'd9, 1'b0, 1'b0, S_DENY, 32'h0,         4'h4}, // R3 global, R6
        '{32'h0001_0123, KR, 1'b1, 8'd9, 1'b0, 1'b0, S_DENY, 32'h0,         4'h4}, // R6 R9
        '{32'h0002_0FFF, KR, 1'b0, 8'd5, 1'b0, 1'b1, S_OK,   32'hC002_0FFF, 4'h1}, // R4 data side
        '{32'h0002_0FFF, KR, 1'b0, 8'd5, 1'b1, 1'b0, S_MISS, 32'h0,         4'h0}, // R4 wrong space
        '{32'h0002_0000, KF, 1'b1, 8'd5, 1'b1, 1'b0, S_OK,   32'hC002_0000, 4'hF}, // R4 instr side
        '{32'h0002_0000, KF, 1'b1, 8'd5, 1'b0, 1'b1, S_MISS, 32'h0,         4'h0}, // R4 fetch uses is
        '{32'h0003_0010, KW, 1'b0, 8'd7, 1'b0, 1'b0, S_OK,   32'hD003_0010, 4'h2}, // R7 first wins
        '{32'h0003_0010, KR, 1'b0, 8'd7, 1'b0, 1'b0, S_OK,   32'hE003_0010, 4'h1}, // R7 continue
        '{32'h0003_0010, KF, 1'b0, 8'd7, 1'b0, 1'b0, S_NX,   32'h0,         4'h1}, // R7 last nibble
        '{32'h0003_0010, KR, 1'b1, 8'd7, 1'b0, 1'b0, S_OK,   32'hD003_0010, 4'h1}, // R5
        '{32'h0004_0000, KR, 1'b0, 8'd5, 1'b0, 1'b0, S_MISS, 32'h0,         4'h0}, // R8 invalid entry
        '{32'h0001_0123, KX, 1'b0, 8'd5, 1'b0, 1'b0, S_OK,   32'hA001_0123, 4'h7}, // R4 kind 11 = read
        '{32'h0001_1123, KR, 1'b0, 8'd5, 1'b0, 1'b0, S_MISS, 32'h0,         4'h0}, // R8 tag mismatch
        '{32'h0001_0123, KR, 1'b0, 8'd0, 1'b0, 1'b0, S_DENY, 32'h0,         4'h4}  // R3 pid compare
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ent(input logic [2:0] idx, input logic v, input logic [19:0] tag,
                             input logic [7:0] pid, input logic [19:0] rpn,
                             input logic as_f, input logic [7:0] perm);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_tag = tag;
        wr_pid = pid; wr_rpn = rpn; wr_as = as_f; wr_perm = perm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Presents one request; returns at the negedge where the response is visible.
    task automatic lookup(input logic [31:0] ea, input logic [1:0] k, input logic sup,
                          input logic [7:0] pid, input logic isb, input logic dsb);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = k; req_priv = sup;
        cur_pid = pid; is_bit = isb; ds_bit = dsb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_tag = '0;
        wr_pid = '0; wr_rpn = '0; wr_as = 1'b0; wr_perm = '0;
        req_valid = 1'b0; req_ea = '0; req_kind = '0; req_priv = 1'b0;
        cur_pid = '0; is_bit = 1'b0; ds_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

        // R1: empty buffer misses
        lookup(32'h0001_0123, KR, 1'b0, 8'd5, 1'b0, 1'b0);
        chk("R1 empty status", 32'(rsp_status), 32'(S_MISS));
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);

        // Load entries
        write_ent(3'd0, 1'b1, 20'h00010, 8'd5, 20'hA0010, 1'b0, 8'h37);
        write_ent(3'd1, 1'b1, 20'h00010, 8'd0, 20'hB0010, 1'b0, 8'h44);
        write_ent(3'd2, 1'b1, 20'h00020, 8'd5, 20'hC0020, 1'b1, 8'hF1);
        write_ent(3'd3, 1'b1, 20'h00030, 8'd7, 20'hD0030, 1'b0, 8'h12);
        write_ent(3'd4, 1'b1, 20'h00030, 8'd7, 20'hE0030, 1'b0, 8'h21);
        write_ent(3'd5, 1'b0, 20'h00040, 8'd5, 20'hF0040, 1'b0, 8'hFF);

        for (int v = 0; v < NV; v++) begin
            lookup(VECS[v].ea, VECS[v].kind, VECS[v].sup, VECS[v].pid, VECS[v].isb, VECS[v].dsb);
            chk($sformatf("R6 vec%0d status", v), 32'(rsp_status), 32'(VECS[v].st));
            chk($sformatf("R3 vec%0d ra", v), rsp_ra, VECS[v].ra);
            chk($sformatf("R7 vec%0d perm", v), 32'(rsp_perm), 32'(VECS[v].perm));
        end

        // R10: no response in an idle cycle
        @(negedge clk);
        chk("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R2: a new entry is visible in the next cycle
        write_ent(3'd6, 1'b1, 20'h00050, 8'd0, 20'h12345, 1'b0, 8'h01);
        lookup(32'h0005_0ABC, KR, 1'b0, 8'd3, 1'b0, 1'b0);
        chk("R2 new entry status", 32'(rsp_status), 32'(S_OK));
        chk("R2 new entry ra", rsp_ra, 32'h1234_5ABC);

        // R2: overwrite entry 0 invalid; read that hit it now falls to entry 1
        write_ent(3'd0, 1'b0, 20'h00010, 8'd5, 20'hA0010, 1'b0, 8'h37);
        lookup(32'h0001_0123, KF, 1'b0, 8'd5, 1'b0, 1'b0);
        chk("R2 overwrite ra", rsp_ra, 32'hB001_0123);
        chk("R5 overwrite perm", 32'(rsp_perm), 32'h4);

        // R10: back-to-back requests each get a response
        @(negedge clk);
        req_valid = 1'b1; req_ea = 32'h0003_0010; req_kind = KW; req_priv = 1'b0;
        cur_pid = 8'd7; is_bit = 1'b0; ds_bit = 1'b0;
        @(negedge clk);
        chk("R10 first of pair", 32'(rsp_valid), 32'd1);
        chk("R7 first of pair ra", rsp_ra, 32'hD003_0010);
        req_kind = KR;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 second of pair", 32'(rsp_valid), 32'd1);
        chk("R7 second of pair ra", rsp_ra, 32'hE003_0010);
        @(negedge clk);
        chk("R10 after pair", 32'(rsp_valid), 32'd0);

        // R1: reset clears all entries again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rsp_valid after re-reset", 32'(rsp_valid), 32'd0);
        lookup(32'h0005_0ABC, KR, 1'b0, 8'd3, 1'b0, 1'b0);
        chk("R1 entries cleared", 32'(rsp_status), 32'(S_MISS));
        chk("R9 miss ra", rsp_ra, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule